// File: doc/BRIEF.md
# AUX Request Header Framer

This block turns one AUX channel request into the ordered byte stream that a channel engine's transmit buffer expects, and then hands the request over to that engine. A request is offered with a one-cycle `start` strobe. It carries a 4-bit command code, a 20-bit target address, a payload length, a write flag, up to `MAX_LEN` write data bytes and a start delay value. The framer captures all of these, reports the total byte count the engine must transmit, and sends the bytes one by one over a valid/ready byte stream.

The stream always begins with three address bytes. The first of these also carries the command. A length byte follows when the length is nonzero, and the payload bytes follow only for write requests. Once the last byte has been accepted, the framer pulses an acknowledge that clears the engine's done flag. It then polls that flag at fixed intervals and issues a single-cycle `go` as soon as the flag reads clear. If the flag is still set after a bounded number of polls, `go` is issued anyway. Reply decoding and line coding belong to other blocks.

Top module: `aux_req_framer`

## Requirements
- R1: Byte 0 of every frame carries the command in bits 7:4 and address bits 19:16 in bits 3:0.
- R2: Byte 1 is address bits 15:8 and byte 2 is address bits 7:0.
- R3: When the captured length L is nonzero, byte 3 is L-1. When L is zero, no length byte is sent.
- R4: From the cycle after capture until `go`, `wr_bytes` holds (L nonzero ? 4 : 3) plus L for writes, or plus 0 for reads. The frame contains exactly that many bytes.
- R5: For writes, the L payload bytes follow the header, with payload byte 0 (taken from `pay_data[7:0]`) first and byte i from `pay_data[8i+7:8i]`. Reads send the header only.
- R6: A requested length above `MAX_LEN` is captured as `MAX_LEN`.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged in the next cycle.
- R8: `done_ack` pulses for exactly one cycle per frame, in the cycle after the last byte is accepted. `go` comes later.
- R9: The done flag is first polled in the cycle after `done_ack` and then every `POLL_STEP` cycles. `go` follows one cycle after the first poll that finds `eng_done` low. After `TIMEOUT_CYC/POLL_STEP` polls that all find it high, `go` follows the last of them.
- R10: `go` lasts one cycle. `busy` is high from the cycle after capture through the `go` cycle and low after it. After reset, `busy`, `tx_valid`, `done_ack` and `go` are low.
- R11: A `start` strobe while `busy` is high is ignored. The frame in progress, its byte count and its start delay are unchanged.
- R12: `start_dly` holds the delay value captured with the request for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, captured when idle |
| req_cmd | input | 4 | Command code |
| req_addr | input | 20 | Target address |
| req_len | input | LEN_W | Requested payload length |
| req_wr | input | 1 | Write request flag |
| req_dly | input | DLY_W | Start delay value to forward |
| pay_data | input | MAX_LEN*8 | Write payload, byte i at bits 8i+7:8i |
| tx_valid | output | 1 | Byte stream valid |
| tx_ready | input | 1 | Byte stream ready |
| tx_data | output | 8 | Byte stream data |
| wr_bytes | output | CNT_W | Total bytes the engine transmits |
| start_dly | output | DLY_W | Captured start delay |
| done_ack | output | 1 | One-cycle clear of the engine done flag |
| eng_done | input | 1 | Engine done flag |
| go | output | 1 | One-cycle engine launch |
| busy | output | 1 | Framer occupied |

## Verification
The assertions take for granted that `tx_ready` can be withdrawn at any time and that `eng_done` may be at either level during the wait. They rely on no relation between `start` and `busy`. The stimulus drives `tx_ready` at a random duty of 30 to 100 percent. It models the engine flag as staying set for a chosen number of cycles after `done_ack`. That hold time ranges from zero up to values beyond the poll budget, which reaches the timeout path. Lengths are drawn above `MAX_LEN` as well as at zero and at the limit. Extra `start` strobes with different fields are injected during frames to show that they have no effect.

// File: rtl/aux_frm_pkg.sv
package aux_frm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_ACK,
    ST_WAIT,
    ST_GO
  } frm_state_e;

  localparam int HDR_BYTES = 3;
endpackage

// File: rtl/aux_frm_pbuf.sv
module aux_frm_pbuf #(
  parameter int MAX_LEN = 16,
  parameter int IDX_W   = 5
) (
  input  logic                 clk,
  input  logic                 load,
  input  logic [MAX_LEN*8-1:0] din,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [7:0]           dout
);
  localparam int AW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  logic [7:0] mem [MAX_LEN];

  // Payload bytes are captured together with the request header fields.
  for (genvar g = 0; g < MAX_LEN; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (load) mem[g] <= din[g*8 +: 8];
    end
  end

  always_comb begin
    if (rd_idx < IDX_W'(MAX_LEN)) dout = mem[rd_idx[AW-1:0]];
    else                          dout = 8'h00;
  end
endmodule

// File: rtl/aux_frm_poll.sv
module aux_frm_poll #(
  parameter int POLL_STEP = 10,
  parameter int MAX_POLLS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic eng_done,
  output logic fire
);
  localparam int SW = (POLL_STEP > 1) ? $clog2(POLL_STEP) : 1;
  localparam int PW = $clog2(MAX_POLLS + 1);

  logic [SW-1:0] step_q;
  logic [PW-1:0] polls_q;
  logic          tick;

  assign tick = en && (step_q == '0);
  assign fire = tick && (!eng_done || (polls_q == PW'(MAX_POLLS - 1)));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      step_q  <= '0;
      polls_q <= '0;
    end else begin
      if (step_q == SW'(POLL_STEP - 1)) step_q <= '0;
      else                               step_q <= step_q + SW'(1);
      if (tick) polls_q <= polls_q + PW'(1);
    end
  end
endmodule

// File: rtl/aux_frm_hdr.sv
module aux_frm_hdr #(
  parameter int LEN_W = 5,
  parameter int CNT_W = 5
) (
  input  logic [3:0]       cmd,
  input  logic [19:0]      addr,
  input  logic [LEN_W-1:0] len,
  input  logic             is_wr,
  input  logic [CNT_W-1:0] idx,
  input  logic [7:0]       pay_byte,
  output logic [7:0]       byte_out,
  output logic [CNT_W-1:0] total,
  output logic [CNT_W-1:0] pay_idx
);
  import aux_frm_pkg::*;

  logic has_len;

  assign has_len = (len != '0);
  assign total   = CNT_W'(has_len ? HDR_BYTES + 1 : HDR_BYTES)
                 + (is_wr ? CNT_W'(len) : CNT_W'(0));
  assign pay_idx = idx - CNT_W'(HDR_BYTES + 1);

  always_comb begin
    case (idx)
      CNT_W'(0): byte_out = {cmd, addr[19:16]};
      CNT_W'(1): byte_out = addr[15:8];
      CNT_W'(2): byte_out = addr[7:0];
      CNT_W'(3): byte_out = 8'(len - LEN_W'(1));
      default:   byte_out = pay_byte;
    endcase
  end
endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer #(
  parameter int MAX_LEN     = 16,
  parameter int LEN_W       = 5,
  parameter int DLY_W       = 4,
  parameter int POLL_STEP   = 10,
  parameter int TIMEOUT_CYC = 80,
  parameter int CNT_W       = $clog2(MAX_LEN + 5)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [3:0]           req_cmd,
  input  logic [19:0]          req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic                 req_wr,
  input  logic [DLY_W-1:0]     req_dly,
  input  logic [MAX_LEN*8-1:0] pay_data,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  output logic [7:0]           tx_data,
  output logic [CNT_W-1:0]     wr_bytes,
  output logic [DLY_W-1:0]     start_dly,
  output logic                 done_ack,
  input  logic                 eng_done,
  output logic                 go,
  output logic                 busy
);
  import aux_frm_pkg::*;

  localparam int MAX_POLLS = (TIMEOUT_CYC / POLL_STEP > 0) ? TIMEOUT_CYC / POLL_STEP : 1;

  frm_state_e       state_q;
  logic [CNT_W-1:0] idx_q;
  logic [3:0]       cmd_q;
  logic [19:0]      addr_q;
  logic [LEN_W-1:0] len_q;
  logic             wr_q;
  logic [DLY_W-1:0] dly_q;

  logic             take;
  logic [LEN_W-1:0] len_clamped;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] pay_idx;
  logic [7:0]       pay_byte;
  logic [7:0]       hdr_byte;
  logic             poll_fire;

  assign take        = start && (state_q == ST_IDLE);
  assign len_clamped = (req_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : req_len;

  aux_frm_pbuf #(.MAX_LEN(MAX_LEN), .IDX_W(CNT_W)) u_pbuf (
    .clk    (clk),
    .load   (take),
    .din    (pay_data),
    .rd_idx (pay_idx),
    .dout   (pay_byte)
  );

  aux_frm_hdr #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_hdr (
    .cmd      (cmd_q),
    .addr     (addr_q),
    .len      (len_q),
    .is_wr    (wr_q),
    .idx      (idx_q),
    .pay_byte (pay_byte),
    .byte_out (hdr_byte),
    .total    (total),
    .pay_idx  (pay_idx)
  );

  aux_frm_poll #(.POLL_STEP(POLL_STEP), .MAX_POLLS(MAX_POLLS)) u_poll (
    .clk      (clk),
    .rst      (rst),
    .en       (state_q == ST_WAIT),
    .eng_done (eng_done),
    .fire     (poll_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      wr_q    <= 1'b0;
      dly_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (take) begin
            cmd_q   <= req_cmd;
            addr_q  <= req_addr;
            len_q   <= len_clamped;
            wr_q    <= req_wr;
            dly_q   <= req_dly;
            idx_q   <= '0;
            state_q <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (tx_ready) begin
            if (idx_q == total - CNT_W'(1)) state_q <= ST_ACK;
            else                            idx_q   <= idx_q + CNT_W'(1);
          end
        end
        ST_ACK:  state_q <= ST_WAIT;
        ST_WAIT: if (poll_fire) state_q <= ST_GO;
        ST_GO:   state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Outputs are decodes of registered state and registered fields.
  assign tx_valid  = (state_q == ST_SEND);
  assign tx_data   = tx_valid ? hdr_byte : 8'h00;
  assign done_ack  = (state_q == ST_ACK);
  assign go        = (state_q == ST_GO);
  assign busy      = (state_q != ST_IDLE);
  assign wr_bytes  = total;
  assign start_dly = dly_q;
endmodule

// File: rtl/aux_req_framer_chk.sv
module aux_req_framer_chk #(
  parameter int CNT_W = 5,
  parameter int DLY_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic [CNT_W-1:0] wr_bytes,
  input logic [DLY_W-1:0] start_dly,
  input logic             done_ack,
  input logic             go,
  input logic             busy
);
  a_r7_hold_stream: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  a_r8_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    done_ack |=> !done_ack && !go);

  a_r8_ack_not_streaming: assert property (@(posedge clk) disable iff (rst)
    done_ack |-> !tx_valid);

  a_r10_go_pulse: assert property (@(posedge clk) disable iff (rst)
    go |=> !go && !busy);

  a_r10_go_busy: assert property (@(posedge clk) disable iff (rst)
    go |-> busy);

  a_r10_valid_busy: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> busy);

  a_r4_count_stable: assert property (@(posedge clk) disable iff (rst)
    $past(busy) && busy |-> $stable(wr_bytes));

  a_r12_dly_stable: assert property (@(posedge clk) disable iff (rst)
    $past(busy) && busy |-> $stable(start_dly));
endmodule

bind aux_req_framer aux_req_framer_chk #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .wr_bytes  (wr_bytes),
  .start_dly (start_dly),
  .done_ack  (done_ack),
  .go        (go),
  .busy      (busy)
);

// File: tb/tb_aux_req_framer.sv
module tb_aux_req_framer;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN    = 16;
  localparam int LEN_W      = 5;
  localparam int DLY_W      = 4;
  localparam int STEP       = 10;
  localparam int TMO        = 80;
  localparam int MAXP       = TMO / STEP;
  localparam int CNT_W      = $clog2(MAX_LEN + 5);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [3:0] req_cmd = '0;
  logic [19:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_wr = 1'b0;
  logic [DLY_W-1:0] req_dly = '0;
  logic [MAX_LEN*8-1:0] pay_data = '0;
  logic tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic [CNT_W-1:0] wr_bytes;
  logic [DLY_W-1:0] start_dly;
  logic done_ack, go, busy;
  logic eng_done = 1'b1;

  int checks = 0;
  int failures = 0;

  logic [3:0]  e_cmd;
  logic [19:0] e_addr;
  int          e_len;
  logic        e_wr;
  logic [7:0]  pay [MAX_LEN];
  logic [7:0]  got [32];
  int          n_got;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_req_framer #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .DLY_W(DLY_W),
                   .POLL_STEP(STEP), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst(rst), .start(start), .req_cmd(req_cmd), .req_addr(req_addr),
    .req_len(req_len), .req_wr(req_wr), .req_dly(req_dly), .pay_data(pay_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .wr_bytes(wr_bytes), .start_dly(start_dly), .done_ack(done_ack),
    .eng_done(eng_done), .go(go), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_total();
    return ((e_len != 0) ? 4 : 3) + (e_wr ? e_len : 0);
  endfunction

  function automatic logic [7:0] exp_byte(input int k);
    if (k == 0) return {e_cmd, e_addr[19:16]};
    if (k == 1) return e_addr[15:8];
    if (k == 2) return e_addr[7:0];
    if (k == 3) return 8'(e_len - 1);
    return pay[k-4];
  endfunction

  function automatic int exp_delta(input int clr);
    int m;
    if (clr <= 1) m = 0;
    else m = (clr - 1 + STEP - 1) / STEP;
    if (m > MAXP - 1) m = MAXP - 1;
    return 2 + m * STEP;
  endfunction

  task automatic run_frame(input logic [3:0] c, input logic [19:0] a, input int l,
                           input logic w, input logic [3:0] d, input int clr,
                           input int rdy_pct, input bit poke);
    int ack_cyc, acks, it, bad_busy;
    bit prev_v, prev_r, seen_ack, seen_go;
    logic [7:0] prev_d;
    for (int i = 0; i < MAX_LEN; i++) begin
      pay[i] = 8'($urandom);
      pay_data[i*8 +: 8] = pay[i];
    end
    e_cmd = c; e_addr = a; e_wr = w;
    e_len = (l > MAX_LEN) ? MAX_LEN : l;
    @(negedge clk);
    req_cmd = c; req_addr = a; req_len = LEN_W'(l); req_wr = w; req_dly = d;
    start = 1'b1; eng_done = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n_got = 0; acks = 0; ack_cyc = 0; bad_busy = 0;
    prev_v = 0; prev_r = 0; prev_d = 0; seen_ack = 0; seen_go = 0;
    chk(wr_bytes == CNT_W'(exp_total()), "R4 byte count", wr_bytes, exp_total());
    chk(start_dly == d, "R12 start delay", start_dly, d);
    for (it = 0; it < 400 && !seen_go; it++) begin
      if (it > 0) @(negedge clk);
      if (poke && it == 1) begin
        req_cmd = ~c; req_addr = ~a; req_len = 5'd2; req_wr = ~w; req_dly = ~d;
        for (int i = 0; i < MAX_LEN; i++) pay_data[i*8 +: 8] = ~pay[i];
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (poke && it == 2) begin
        chk(wr_bytes == CNT_W'(exp_total()), "R11 count after ignored start",
            wr_bytes, exp_total());
        chk(start_dly == d, "R11 delay after ignored start", start_dly, d);
      end
      if (prev_v && !prev_r)
        chk(tx_valid && tx_data == prev_d, "R7 hold under backpressure", tx_data, prev_d);
      if (!busy) bad_busy++;
      if (done_ack) begin
        acks++; seen_ack = 1; ack_cyc = it;
      end
      if (go) begin
        seen_go = 1;
        chk(seen_ack && acks == 1, "R8 single ack before go", acks, 1);
        chk(it - ack_cyc == exp_delta(clr), "R9 go timing", it - ack_cyc, exp_delta(clr));
      end
      if (seen_ack) eng_done = ((it - ack_cyc) < clr);
      prev_v = tx_valid; prev_d = tx_data;
      tx_ready = (($urandom % 100) < rdy_pct);
      prev_r = tx_ready;
      if (tx_valid && tx_ready && n_got < 32) begin
        got[n_got] = tx_data; n_got++;
      end
    end
    start = 1'b0;
    chk(bad_busy == 0, "R10 busy through frame", bad_busy, 0);
    @(negedge clk);
    chk(!busy && !go, "R10 idle after go", busy, 0);
    tx_ready = 1'b0; eng_done = 1'b1;
    chk(n_got == exp_total(), (l > MAX_LEN) ? "R6 clamped frame length" : "R4 frame length",
        n_got, exp_total());
    if (n_got >= 3) begin
      chk(got[0] == exp_byte(0), "R1 command and high address", got[0], exp_byte(0));
      chk(got[1] == exp_byte(1) && got[2] == exp_byte(2), "R2 address bytes",
          {got[1], got[2]}, {exp_byte(1), exp_byte(2)});
    end
    if (e_len != 0 && n_got >= 4)
      chk(got[3] == exp_byte(3), "R3 length byte", got[3], exp_byte(3));
    if (e_wr && n_got == exp_total()) begin
      for (int k = 4; k < n_got; k++)
        chk(got[k] == exp_byte(k), poke ? "R11 payload unchanged" : "R5 payload order",
            got[k], exp_byte(k));
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0A11));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !tx_valid && !go && !done_ack, "R10 reset state",
        {busy, tx_valid, go, done_ack}, 0);
    // directed corners
    run_frame(4'h9, 20'hABCDE, 0,  1'b0, 4'h3, 0,   100, 0); // R3 read, no length byte
    run_frame(4'h9, 20'h12345, 5,  1'b0, 4'h1, 1,   100, 0); // R5 read header only
    run_frame(4'h8, 20'h00F0F, 0,  1'b1, 4'h7, 11,  60,  0); // write with zero length
    run_frame(4'h0, 20'hFFFFF, 16, 1'b1, 4'hF, 12,  40,  0); // R5 full payload
    run_frame(4'h4, 20'h54321, 20, 1'b1, 4'h2, 3,   80,  0); // R6 clamp
    run_frame(4'h5, 20'h0A0A0, 27, 1'b0, 4'h0, 5,   100, 0); // R6 clamp on read
    run_frame(4'h1, 20'h33333, 3,  1'b1, 4'h5, 500, 70,  0); // R9 timeout path
    run_frame(4'hC, 20'h77777, 4,  1'b1, 4'h9, 21,  50,  1); // R11 start while busy
    for (int r = 0; r < 30; r++)
      run_frame(4'($urandom), 20'($urandom), $urandom % 21, 1'($urandom),
                4'($urandom), $urandom % 100, 30 + $urandom % 71, ($urandom % 4) == 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule